// File: doc/BRIEF.md
# Serial Receiver with Count-Threshold Queue

This block takes an asynchronous serial line and turns it into entries in a receive queue. A small memory-mapped register file controls it. A programmable divisor sets an oversampling tick. The receiver samples each bit near its centre and can check odd or even parity. Each character goes into the queue with two error flags of its own. The payload keeps the low six bits of the character. Bit 6 holds the parity error and bit 7 holds the framing error.

Software reads entries one at a time from the data register. The status register reports two things: that the queue holds at least N+1 entries, where N is a programmable count, and that the queue is full. A level interrupt follows the count condition when the interrupt enable bit is set. A self-clearing control bit empties the queue.

Top module: `uart_rx_fifo_top`

## Requirements
- R1: After reset the control register (address 0) reads 0, the status register (address 2) reads 0, the data register (address 3) reads 0, the count register (address 1) reads BAUD_RST, and the interrupt is low.
- R2: The receiver takes a frame made of a low start bit, DATA_BITS data bits LSB first, an optional parity bit and a high stop bit. Each bit lasts 16 ticks, and a tick lasts D clocks, where D is bits 7:0 of address 1 (a value of 0 counts as 1). The queued entry carries data bits 5:0 in its bits 5:0.
- R3: Control bits 1:0 choose the parity mode: 0 none, 1 odd, 2 even, 3 none. With odd or even parity, a parity bit that does not match the data sets entry bit 6. With no parity, bit 6 stays 0 and no parity bit is expected.
- R4: A stop bit that samples low sets entry bit 7. A high stop bit leaves bit 7 clear.
- R5: Reading address 3 with the read strobe returns the oldest entry in its upper-byte-zero form and removes it, so entries come out in arrival order. A read while the queue is empty returns 0 and changes nothing.
- R6: Status bit 0 is 1 exactly while the queue holds at least N+1 entries, where N is bits 15:8 of address 1.
- R7: Status bit 1 is 1 while the queue holds FIFO_DEPTH entries. A character that completes while the queue is full is dropped.
- R8: Writing control bit 5 as 1 empties the queue on the following clock. That bit reads back 0 from then on. A flush wins over a character arriving in the same cycle.
- R9: The interrupt output is the level AND of control bit 4 and status bit 0.
- R10: A low pulse on the line shorter than half a bit is not taken as a start bit and queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the data address) |
| reg_addr | input | 2 | Register select: 0 control, 1 divisor/count, 2 status, 3 data |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with FIFO_DEPTH set to 4 and keeps the default eight data bits and two synchroniser stages. With the small depth, the full flag and the dropped fifth character come after only a few frames. It also lets the random batches cover every count threshold from N = 0 up to beyond the depth. The divisor is set to 2, so one bit lasts 32 clocks. Parity modes, error injection and batch sizes are then drawn at random for many frames.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_ODD  = 2'd1,
      PAR_EVEN = 2'd2,
      PAR_OFF3 = 2'd3
   } par_mode_e;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_DIV  = 2'd1;
   localparam logic [1:0] ADR_STAT = 2'd2;
   localparam logic [1:0] ADR_DATA = 2'd3;

   localparam int CTL_IEN_BIT   = 4;
   localparam int CTL_FLUSH_BIT = 5;

   localparam int ENTRY_W = 8;

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] limit;

   always_comb begin
      limit  = (div_i == '0) ? '0 : div_i - 1'b1;
      tick_o = (cnt_q >= limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
   import uart_rx_pkg::*;
#(
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               rx_i,
   input  logic [1:0]         par_mode_i,
   output logic               push_o,
   output logic [ENTRY_W-1:0] entry_o
);
   localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
   localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

   // input synchroniser, length chosen by parameter
   logic [SYNC_STAGES-1:0] sync_q;
   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[0] <= 1'b1;
               else        sync_q[0] <= rx_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[gi] <= 1'b1;
               else        sync_q[gi] <= sync_q[gi-1];
         end
      end
   endgenerate

   logic rx_s, rx_prev_q;
   assign rx_s = sync_q[SYNC_STAGES-1];

   rx_state_e              st_q;
   logic [3:0]             tcnt_q;
   logic [BW-1:0]          bcnt_q;
   logic [DATA_BITS-1:0]   shr_q;
   logic                   pbit_q;
   logic                   par_on;
   logic                   par_bad;

   always_comb begin
      par_on = (par_mode_i == PAR_ODD) || (par_mode_i == PAR_EVEN);
      if (par_mode_i == PAR_ODD) par_bad = ~(^{shr_q, pbit_q});
      else                       par_bad =  (^{shr_q, pbit_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= RX_IDLE;
         tcnt_q    <= '0;
         bcnt_q    <= '0;
         shr_q     <= '0;
         pbit_q    <= 1'b0;
         rx_prev_q <= 1'b1;
         push_o    <= 1'b0;
         entry_o   <= '0;
      end else begin
         rx_prev_q <= rx_s;
         push_o    <= 1'b0;
         unique case (st_q)
            RX_IDLE: begin
               if (rx_prev_q && !rx_s) begin
                  st_q   <= RX_START;
                  tcnt_q <= '0;
               end
            end
            RX_START: if (tick_i) begin
               if (tcnt_q == 4'd7) begin
                  tcnt_q <= '0;
                  bcnt_q <= '0;
                  st_q   <= rx_s ? RX_IDLE : RX_DATA;
               end else tcnt_q <= tcnt_q + 1'b1;
            end
            RX_DATA: if (tick_i) begin
               tcnt_q <= tcnt_q + 1'b1;
               if (tcnt_q == 4'd15) begin
                  shr_q[bcnt_q] <= rx_s;
                  if (bcnt_q == LAST_BIT) st_q <= par_on ? RX_PAR : RX_STOP;
                  else                    bcnt_q <= bcnt_q + 1'b1;
               end
            end
            RX_PAR: if (tick_i) begin
               tcnt_q <= tcnt_q + 1'b1;
               if (tcnt_q == 4'd15) begin
                  pbit_q <= rx_s;
                  st_q   <= RX_STOP;
               end
            end
            RX_STOP: if (tick_i) begin
               tcnt_q <= tcnt_q + 1'b1;
               if (tcnt_q == 4'd15) begin
                  push_o  <= 1'b1;
                  entry_o <= {~rx_s, par_on & par_bad, shr_q[5:0]};
                  st_q    <= RX_IDLE;
               end
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end

   AST_PUSH_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |-> (st_q == RX_IDLE)) else $error("push outside idle"); // R2
   AST_NO_PERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (push_o && $stable(par_mode_i) && (par_mode_i == PAR_NONE)) |-> !entry_o[6])
      else $error("parity error with parity off"); // R3
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush_i,
   input  logic                     push_i,
   input  logic [WIDTH-1:0]         din_i,
   input  logic                     pop_i,
   output logic [WIDTH-1:0]         head_o,
   output logic [$clog2(DEPTH):0]   count_o,
   output logic                     full_o,
   output logic                     empty_o
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic             do_push, do_pop;

   assign full_o  = (count_o == DEPTH_C);
   assign empty_o = (count_o == '0);
   assign head_o  = mem_q[rp_q];
   assign do_push = push_i && !full_o && !flush_i;
   assign do_pop  = pop_i && !empty_o && !flush_i;

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wp_q] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q    <= '0;
         rp_q    <= '0;
         count_o <= '0;
      end else if (flush_i) begin
         wp_q    <= '0;
         rp_q    <= '0;
         count_o <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count_o <= count_o + 1'b1;
            2'b01:   count_o <= count_o - 1'b1;
            default: count_o <= count_o;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= DEPTH_C) else $error("queue overflow"); // R7
   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && push_i && !pop_i && !flush_i) |=> full_o) else $error("full lost"); // R7
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> empty_o) else $error("flush left data"); // R8
endmodule

// File: rtl/uart_rx_fifo_top.sv
module uart_rx_fifo_top
   import uart_rx_pkg::*;
#(
   parameter int          FIFO_DEPTH  = 8,
   parameter int          DATA_BITS   = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [15:0] BAUD_RST    = 16'h00D8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [1:0]  reg_addr,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   input  logic        rx_i,
   output logic        irq_o
);
   localparam int CW = $clog2(FIFO_DEPTH) + 1;

   generate
      if ((FIFO_DEPTH < 2) || ((FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two of at least 2");
      end
      if ((DATA_BITS < 6) || (DATA_BITS > 9)) begin : g_bad_bits
         $error("DATA_BITS must lie in 6..9");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [1:0]         par_q;
   logic               ien_q;
   logic               flush_q;
   logic [15:0]        div_q;
   logic               tick;
   logic               push;
   logic [ENTRY_W-1:0] entry, head;
   logic [CW-1:0]      count;
   logic               full, empty, avail, pop;
   logic [8:0]         need;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q   <= 2'd0;
         ien_q   <= 1'b0;
         flush_q <= 1'b0;
         div_q   <= BAUD_RST;
      end else begin
         flush_q <= 1'b0;
         if (reg_wr && reg_addr == ADR_CTRL) begin
            par_q   <= reg_wdata[1:0];
            ien_q   <= reg_wdata[CTL_IEN_BIT];
            flush_q <= reg_wdata[CTL_FLUSH_BIT];
         end
         if (reg_wr && reg_addr == ADR_DIV) div_q <= reg_wdata;
      end
   end

   assign need  = {1'b0, div_q[15:8]} + 9'd1;
   assign avail = (9'(count) >= need);
   assign irq_o = ien_q & avail;
   assign pop   = reg_rd && (reg_addr == ADR_DATA) && !empty;

   always_comb begin
      unique case (reg_addr)
         ADR_CTRL: reg_rdata = {10'd0, flush_q, ien_q, 2'd0, par_q};
         ADR_DIV:  reg_rdata = div_q;
         ADR_STAT: reg_rdata = {14'd0, full, avail};
         default:  reg_rdata = empty ? 16'd0 : {8'd0, head};
      endcase
   end

   uart_rx_tick #(.DIV_W(8)) u_tick (
      .clk(clk), .rst_n(rst_n), .div_i(div_q[7:0]), .tick_o(tick)
   );

   uart_rx_fsm #(.DATA_BITS(DATA_BITS), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_i),
      .par_mode_i(par_q), .push_o(push), .entry_o(entry)
   );

   uart_rx_queue #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_q), .push_i(push),
      .din_i(entry), .pop_i(pop), .head_o(head), .count_o(count),
      .full_o(full), .empty_o(empty)
   );

   AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADR_DATA && empty) |-> (reg_rdata == 16'd0)) else $error("empty read"); // R5
   AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !empty) else $error("irq without data"); // R9
   AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_q && !reg_wr) |=> !flush_q) else $error("flush stuck"); // R8
endmodule

// File: tb/uart_rx_fifo_top_tb.sv
module uart_rx_fifo_top_tb;
   localparam int DEPTH = 4;
   localparam int BITCLK = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0, reg_rd = 1'b0, rx = 1'b1;
   logic [1:0] reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'd0, reg_rdata;
   logic irq;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   uart_rx_fifo_top #(.FIFO_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_i(rx), .irq_o(irq)
   );

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_entry(logic [7:0] d, int mode, bit badp, bit bads);
      exp_entry = {bads, ((mode == 1 || mode == 2) && badp), d[5:0]};
   endfunction

   task automatic wr(logic [1:0] a, logic [15:0] d);
      @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic peek(logic [1:0] a, output logic [15:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   task automatic pop(output logic [15:0] d);
      @(negedge clk); reg_addr = 2'd3; reg_rd = 1; #1 d = reg_rdata;
      @(negedge clk); reg_rd = 0;
   endtask

   task automatic send(logic [7:0] d, int mode, bit badp, bit bads);
      logic p;
      @(negedge clk); rx = 0;
      repeat (BITCLK) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx = d[i];
         repeat (BITCLK) @(negedge clk);
      end
      if (mode == 1 || mode == 2) begin
         p = (mode == 1) ? ~(^d) : (^d);
         rx = p ^ badp;
         repeat (BITCLK) @(negedge clk);
      end
      rx = ~bads;
      repeat (BITCLK) @(negedge clk);
      rx = 1;
      repeat (BITCLK) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] v;
      logic [7:0] qd [DEPTH];
      void'($urandom(32'h5EED_0013));
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      peek(2'd0, v); check("R1 ctrl", v, 16'h0000);
      peek(2'd1, v); check("R1 div", v, 16'h00D8);
      peek(2'd2, v); check("R1 stat", v, 16'h0000);
      peek(2'd3, v); check("R1 data", v, 16'h0000);
      check("R1 irq", {15'd0, irq}, 16'd0);

      wr(2'd1, 16'h0002);
      wr(2'd0, 16'h0000);
      // R2 plain frame
      send(8'hA5, 0, 0, 0);
      peek(2'd2, v); check("R6 avail N=0", v, 16'h0001);
      pop(v); check("R2 payload", v, 16'h0025);
      // R3 parity
      wr(2'd0, 16'h0001);
      send(8'h3C, 1, 0, 0); pop(v); check("R3 odd good", v, 16'h003C);
      send(8'h3C, 1, 1, 0); pop(v); check("R3 odd bad", v, 16'h007C);
      wr(2'd0, 16'h0002);
      send(8'h81, 2, 0, 0); pop(v); check("R3 even good", v, 16'h0001);
      send(8'h81, 2, 1, 0); pop(v); check("R3 even bad", v, 16'h0041);
      wr(2'd0, 16'h0003);
      send(8'h17, 3, 0, 0); pop(v); check("R3 mode3 none", v, 16'h0017);
      // R4 framing
      wr(2'd0, 16'h0000);
      send(8'h5A, 0, 0, 1); pop(v); check("R4 stop low", v, 16'h009A);
      // R5 order and empty read
      send(8'h01, 0, 0, 0); send(8'h02, 0, 0, 0); send(8'h03, 0, 0, 0);
      pop(v); check("R5 first", v, 16'h0001);
      pop(v); check("R5 second", v, 16'h0002);
      pop(v); check("R5 third", v, 16'h0003);
      pop(v); check("R5 empty read", v, 16'h0000);
      peek(2'd2, v); check("R5 empty unchanged", v, 16'h0000);
      // R6 / R9 threshold N=2 with irq enabled
      wr(2'd1, 16'h0202);
      wr(2'd0, 16'h0010);
      send(8'h11, 0, 0, 0); send(8'h12, 0, 0, 0);
      peek(2'd2, v); check("R6 below thr", v, 16'h0000);
      check("R9 irq low below", {15'd0, irq}, 16'd0);
      send(8'h13, 0, 0, 0);
      peek(2'd2, v); check("R6 at thr", v, 16'h0001);
      check("R9 irq high", {15'd0, irq}, 16'd1);
      wr(2'd0, 16'h0000);
      check("R9 irq gated off", {15'd0, irq}, 16'd0);
      pop(v); check("R6 drain", v, 16'h0011);
      peek(2'd2, v); check("R6 below after pop", v, 16'h0000);
      // R8 flush
      wr(2'd0, 16'h0020);
      @(negedge clk);
      peek(2'd0, v); check("R8 self clear", v, 16'h0000);
      peek(2'd2, v); check("R8 stat empty", v, 16'h0000);
      peek(2'd3, v); check("R8 data empty", v, 16'h0000);
      // R7 full and drop
      wr(2'd1, 16'h0002);
      for (int i = 0; i < 5; i++) send(8'h20 + 8'(i), 0, 0, 0);
      peek(2'd2, v); check("R7 full", v, 16'h0003);
      for (int i = 0; i < 4; i++) begin
         pop(v); check("R7 kept", v, 16'h0020 + 16'(i));
      end
      pop(v); check("R7 dropped", v, 16'h0000);
      // R10 false start
      @(negedge clk); rx = 0;
      repeat (3) @(negedge clk); rx = 1;
      repeat (3 * BITCLK) @(negedge clk);
      peek(2'd2, v); check("R10 glitch stat", v, 16'h0000);
      pop(v); check("R10 glitch data", v, 16'h0000);
      // random batches
      for (int it = 0; it < 12; it++) begin
         int k, n, mode;
         k = 1 + int'($urandom % DEPTH);
         n = int'($urandom % (DEPTH + 1));
         mode = int'($urandom % 4);
         wr(2'd1, {8'(n), 8'h02});
         wr(2'd0, {11'd0, 1'b1, 2'd0, 2'(mode)});
         for (int j = 0; j < k; j++) begin
            logic [7:0] d; bit bp, bs;
            d = 8'($urandom); bp = ($urandom % 3) == 0; bs = ($urandom % 5) == 0;
            qd[j] = exp_entry(d, mode, bp, bs);
            send(d, mode, bp, bs);
         end
         peek(2'd2, v);
         check("R6 R7 random stat", v, {14'd0, (k == DEPTH), (k >= n + 1)});
         check("R9 random irq", {15'd0, irq}, {15'd0, (k >= n + 1)});
         for (int j = 0; j < k; j++) begin
            pop(v); check("R2 R3 R4 random entry", v, {8'd0, qd[j]});
         end
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule